// File: doc/BRIEF.md
# Double-Buffered Frame Swap Controller

This block controls two frame-buffer banks. One bank is scanned out to the display while the other is open to the processor. A single frame-select bit decides which bank has which role. When the processor writes the frame-select bit, the new value is held as pending. It is applied only while the picture is blanked, which means vertical blank is active or the display mode field is zero. If the processor writes the bit while blanking is already in force, the change is applied at once. The current frame-select bit and the pending flag are both visible as status, so software can poll for the moment the swap has completed.

Processor accesses always go to the bank that is not on screen. The processor address window is twice the size of a bank. Its top address bit selects an overwrite alias of the same storage. Through the alias, each byte lane that carries zero has its byte enable dropped, so transparent pixels keep the old contents. No read-modify-write cycle is needed for this.

A mode register holds the display mode field and a priority bit. When the priority bit is written with a new value, the block raises a one-cycle palette-refresh pulse. The bank memories sit outside the block and are reached through a simple single-cycle RAM port.

Top module: `frame_swap_ctrl`

## Requirements
- R1: After reset, the frame-select status is 0 and nothing is pending. The mode register is 0x00 and the palette-refresh pulse is low.
- R2: A frame-select write made while not blanked (vblank_i low and mode bits [1:0] nonzero) leaves the status unchanged and sets the pending flag on the next cycle.
- R3: While a value is pending, the first clock edge at which vblank_i is high applies the pending value to the status and clears the pending flag.
- R4: A frame-select write made while vblank_i is high updates the status on the next cycle and leaves nothing pending.
- R5: A mode field of zero (bits [1:0] = 0) counts as blanking, both for applying a pending value and for immediate writes.
- R6: Every processor access goes to bank = NOT status. The scan-out bank output equals the status.
- R7: The alias bit (cpu address bit BANK_AW) does not change the word address. Outside the alias, every enabled lane is written, including zero bytes. Word address = cpu address bits [BANK_AW-1:1], lane 0 = data bits [7:0].
- R8: Inside the alias, any enabled lane whose write byte is zero is not written. This applies to both 8-bit and 16-bit writes, and the nonzero lanes are still written.
- R9: A mode write that changes bit 7 (priority) gives pal_dirty_o high for exactly one cycle. A write that leaves bit 7 unchanged gives no pulse.
- R10: blank_o is high exactly when vblank_i is high or mode bits [1:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vblank_i | input | 1 | Vertical blank indication |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data (bit 7 priority, bits [1:0] mode field) |
| fs_we_i | input | 1 | Frame-select write strobe |
| fs_wdata_i | input | 1 | Frame-select write value |
| cpu_req_i | input | 1 | Processor frame-memory access request |
| cpu_we_i | input | 1 | Processor write when high, read when low |
| cpu_addr_i | input | BANK_AW+1 | Processor byte address, top bit selects the overwrite alias |
| cpu_be_i | input | DW/8 | Processor byte enables |
| cpu_wdata_i | input | DW | Processor write data |
| cpu_rdata_o | output | DW | Processor read data |
| mode_o | output | 8 | Mode register contents |
| blank_o | output | 1 | Blanking status |
| pal_dirty_o | output | 1 | Palette refresh pulse |
| fs_status_o | output | 1 | Displayed frame-select bit |
| fs_pend_o | output | 1 | A frame-select value is waiting |
| scan_bank_o | output | 1 | Bank being scanned out |
| mem_en_o | output | 1 | RAM port access enable |
| mem_we_o | output | 1 | RAM port write |
| mem_bank_o | output | 1 | RAM port bank select |
| mem_addr_o | output | BANK_AW-1 | RAM port word address |
| mem_be_o | output | DW/8 | RAM port byte-lane write enables |
| mem_wdata_o | output | DW | RAM port write data |
| mem_rdata_i | input | DW | RAM port read data |

## Verification
Frame-select writes are applied under four conditions: during active display, at the first vblank edge, during vblank, and with the display mode off. Comparing these separates deferral from immediate application, and shows whether the mode-off path is recognised as blanking. Writes go through both the normal window and the alias with zero and nonzero data in each lane, in both byte and word form. A stuck or swapped lane mask, or a mask wrongly applied outside the alias, then shows up in the stored word. Read-back after a swap confirms that the processor always sees the hidden bank.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int unsigned LANE_W       = 8;
  localparam int unsigned MODE_W       = 8;
  localparam int unsigned MODE_PRI_BIT = 7;
  localparam int unsigned MODE_FLD_W   = 2;

  function automatic logic mode_is_off(input logic [MODE_W-1:0] m);
    return m[MODE_FLD_W-1:0] == '0;
  endfunction
endpackage

// File: rtl/fsw_mode.sv
module fsw_mode
  import fsw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              off_o,
  output logic              pal_dirty_o
);
  logic [MODE_W-1:0] mode_q;
  logic              dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      dirty_q <= we_i && (wdata_i[MODE_PRI_BIT] != mode_q[MODE_PRI_BIT]);
      if (we_i) mode_q <= wdata_i;
    end
  end

  assign mode_o      = mode_q;
  assign off_o       = mode_is_off(mode_q);
  assign pal_dirty_o = dirty_q;
endmodule

// File: rtl/fsw_select.sv
module fsw_select (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blank_i,
  input  logic we_i,
  input  logic wdata_i,
  output logic fs_o,
  output logic pend_o
);
  logic fs_q, pend_q, pval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= 1'b0;
      pend_q <= 1'b0;
      pval_q <= 1'b0;
    end else if (we_i) begin
      if (blank_i) begin
        fs_q   <= wdata_i;
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        pval_q <= wdata_i;
      end
    end else if (pend_q && blank_i) begin
      fs_q   <= pval_q;
      pend_q <= 1'b0;
    end
  end

  assign fs_o   = fs_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/fsw_steer.sv
module fsw_steer
  import fsw_pkg::*;
#(
  parameter int unsigned BANK_AW = 17,
  parameter int unsigned DW      = 16,
  localparam int unsigned LANES  = DW / LANE_W,
  localparam int unsigned WAW    = BANK_AW - 1
) (
  input  logic             fs_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [BANK_AW:0] addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             en_o,
  output logic             we_o,
  output logic             bank_o,
  output logic [WAW-1:0]   addr_o,
  output logic [LANES-1:0] be_o,
  output logic [DW-1:0]    wdata_o
);
  logic alias_sel;
  assign alias_sel = addr_i[BANK_AW];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic zero_lane;
    assign zero_lane = wdata_i[l*LANE_W +: LANE_W] == '0;
    // overwrite alias: zero byte is transparent
    assign be_o[l] = be_i[l] && !(alias_sel && zero_lane);
  end

  assign en_o    = req_i;
  assign we_o    = req_i && we_i;
  assign bank_o  = ~fs_i;
  assign addr_o  = addr_i[BANK_AW-1:1];
  assign wdata_o = wdata_i;
endmodule

// File: rtl/frame_swap_ctrl.sv
module frame_swap_ctrl
  import fsw_pkg::*;
#(
  parameter int unsigned BANK_AW = 17,
  parameter int unsigned DW      = 16,
  localparam int unsigned LANES  = DW / LANE_W,
  localparam int unsigned WAW    = BANK_AW - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vblank_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              fs_we_i,
  input  logic              fs_wdata_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [BANK_AW:0]  cpu_addr_i,
  input  logic [LANES-1:0]  cpu_be_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  output logic [DW-1:0]     cpu_rdata_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              blank_o,
  output logic              pal_dirty_o,
  output logic              fs_status_o,
  output logic              fs_pend_o,
  output logic              scan_bank_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic              mem_bank_o,
  output logic [WAW-1:0]    mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i
);
  logic disp_off, blank, fs;

  fsw_mode u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (mode_we_i),
    .wdata_i     (mode_wdata_i),
    .mode_o      (mode_o),
    .off_o       (disp_off),
    .pal_dirty_o (pal_dirty_o)
  );

  assign blank = vblank_i || disp_off;

  fsw_select u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .blank_i (blank),
    .we_i    (fs_we_i),
    .wdata_i (fs_wdata_i),
    .fs_o    (fs),
    .pend_o  (fs_pend_o)
  );

  fsw_steer #(.BANK_AW(BANK_AW), .DW(DW)) u_steer (
    .fs_i    (fs),
    .req_i   (cpu_req_i),
    .we_i    (cpu_we_i),
    .addr_i  (cpu_addr_i),
    .be_i    (cpu_be_i),
    .wdata_i (cpu_wdata_i),
    .en_o    (mem_en_o),
    .we_o    (mem_we_o),
    .bank_o  (mem_bank_o),
    .addr_o  (mem_addr_o),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  assign blank_o     = blank;
  assign fs_status_o = fs;
  assign scan_bank_o = fs;
  assign cpu_rdata_o = mem_rdata_i;
endmodule

// File: rtl/frame_swap_ctrl_chk.sv
module frame_swap_ctrl_chk #(
  parameter int unsigned BANK_AW = 17,
  parameter int unsigned DW      = 16,
  localparam int unsigned LANES  = DW / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vblank_i,
  input logic             mode_we_i,
  input logic             fs_we_i,
  input logic             fs_wdata_i,
  input logic [BANK_AW:0] cpu_addr_i,
  input logic [LANES-1:0] cpu_be_i,
  input logic [DW-1:0]    cpu_wdata_i,
  input logic             blank_o,
  input logic             pal_dirty_o,
  input logic             fs_status_o,
  input logic             fs_pend_o,
  input logic             scan_bank_o,
  input logic             mem_en_o,
  input logic             mem_we_o,
  input logic             mem_bank_o,
  input logic [LANES-1:0] mem_be_o
);
  a_r2_hold_when_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_o |=> $stable(fs_status_o));
  a_r2_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_we_i && !blank_o) |=> fs_pend_o);
  a_r3_pend_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fs_we_i && fs_pend_o && blank_o) |=> !fs_pend_o);
  a_r4_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_we_i && blank_o) |=> (fs_status_o == $past(fs_wdata_i)) && !fs_pend_o);
  a_r6_hidden_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_bank_o != scan_bank_o));
  a_r7_plain_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !cpu_addr_i[BANK_AW]) |-> (mem_be_o == cpu_be_i));
  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    a_r8_zero_lane_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we_o && cpu_addr_i[BANK_AW] && cpu_wdata_i[l*8 +: 8] == 8'h00) |-> !mem_be_o[l]);
  end
  a_r9_dirty_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_dirty_o |-> $past(mode_we_i));
  a_r10_vblank_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |-> blank_o);
endmodule

bind frame_swap_ctrl frame_swap_ctrl_chk #(.BANK_AW(BANK_AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vblank_i    (vblank_i),
  .mode_we_i   (mode_we_i),
  .fs_we_i     (fs_we_i),
  .fs_wdata_i  (fs_wdata_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_be_i    (cpu_be_i),
  .cpu_wdata_i (cpu_wdata_i),
  .blank_o     (blank_o),
  .pal_dirty_o (pal_dirty_o),
  .fs_status_o (fs_status_o),
  .fs_pend_o   (fs_pend_o),
  .scan_bank_o (scan_bank_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_bank_o  (mem_bank_o),
  .mem_be_o    (mem_be_o)
);

// File: tb/frame_swap_ctrl_bench.sv
module frame_swap_ctrl_bench;
  localparam int unsigned BANK_AW = 10;
  localparam int unsigned DW      = 16;
  localparam int unsigned LANES   = DW / 8;
  localparam int unsigned WORDS   = 1 << (BANK_AW - 1);
  localparam logic [BANK_AW:0] ALIAS = 1 << BANK_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic vblank = 0, mode_we = 0, fs_we = 0, fs_wd = 0;
  logic [7:0] mode_wd = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [BANK_AW:0] cpu_addr = 0;
  logic [LANES-1:0] cpu_be = 0;
  logic [DW-1:0] cpu_wd = 0;
  logic [DW-1:0] cpu_rd, mem_wd, mem_rd;
  logic [7:0] mode;
  logic blank, pal_dirty, fs_stat, fs_pend, scan_bank;
  logic mem_en, mem_we, mem_bank;
  logic [BANK_AW-2:0] mem_addr;
  logic [LANES-1:0] mem_be;

  logic [DW-1:0] ram0 [WORDS];
  logic [DW-1:0] ram1 [WORDS];

  int checks = 0;
  int failures = 0;

  frame_swap_ctrl #(.BANK_AW(BANK_AW), .DW(DW)) u_frame_swap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .vblank_i(vblank),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .fs_we_i(fs_we), .fs_wdata_i(fs_wd),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_be_i(cpu_be), .cpu_wdata_i(cpu_wd), .cpu_rdata_o(cpu_rd),
    .mode_o(mode), .blank_o(blank), .pal_dirty_o(pal_dirty),
    .fs_status_o(fs_stat), .fs_pend_o(fs_pend), .scan_bank_o(scan_bank),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_bank_o(mem_bank),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wd),
    .mem_rdata_i(mem_rd)
  );

  // external bank RAM model
  initial begin
    for (int i = 0; i < WORDS; i++) begin
      ram0[i] = '0;
      ram1[i] = '0;
    end
  end
  always @(posedge clk) begin
    if (mem_en && mem_we)
      for (int l = 0; l < LANES; l++)
        if (mem_be[l]) begin
          if (mem_bank) ram1[mem_addr][l*8 +: 8] <= mem_wd[l*8 +: 8];
          else          ram0[mem_addr][l*8 +: 8] <= mem_wd[l*8 +: 8];
        end
  end
  assign mem_rd = mem_bank ? ram1[mem_addr] : ram0[mem_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1; mode_wd = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic write_fs(input logic v);
    @(negedge clk); fs_we = 1; fs_wd = v;
    @(negedge clk); fs_we = 0;
  endtask

  task automatic set_vblank(input logic v);
    @(negedge clk); vblank = v;
  endtask

  task automatic cpu_write(input logic [BANK_AW:0] a, input logic [DW-1:0] d,
                           input logic [LANES-1:0] be);
    @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wd = d; cpu_be = be;
    @(negedge clk); cpu_req = 0; cpu_we = 0; cpu_be = 0;
  endtask

  task automatic cpu_read(input logic [BANK_AW:0] a, output logic [DW-1:0] d,
                          output logic bank);
    @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = a;
    #1; d = cpu_rd; bank = mem_bank;
    @(negedge clk); cpu_req = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", fs_stat, 0);
    chk("R1 pend", fs_pend, 0);
    chk("R1 mode", mode, 8'h00);
    chk("R1 pal_dirty", pal_dirty, 0);
  endtask

  task automatic t_deferred;
    set_mode(8'h01);
    write_fs(1);
    chk("R2 status held", fs_stat, 0);
    chk("R2 pend set", fs_pend, 1);
    repeat (3) @(negedge clk);
    chk("R2 still held", fs_stat, 0);
    set_vblank(1);
    @(negedge clk);
    chk("R3 applied at vblank", fs_stat, 1);
    chk("R3 pend cleared", fs_pend, 0);
    set_vblank(0);
  endtask

  task automatic t_immediate;
    set_vblank(1);
    write_fs(0);
    chk("R4 immediate", fs_stat, 0);
    chk("R4 no pend", fs_pend, 0);
    set_vblank(0);
  endtask

  task automatic t_display_off;
    write_fs(1);
    chk("R5 pend before off", fs_pend, 1);
    set_mode(8'h00);
    chk("R5 not yet", fs_stat, 0);
    @(negedge clk);
    chk("R5 applied by off", fs_stat, 1);
    write_fs(0);
    chk("R5 immediate off", fs_stat, 0);
    chk("R5 no pend", fs_pend, 0);
    set_mode(8'h01);
  endtask

  task automatic t_steer;
    logic [DW-1:0] d;
    logic b;
    chk("R6 scan bank", scan_bank, 0);
    cpu_write(4, 16'h1234, 2'b11);
    chk("R6 hidden bank written", ram1[2], 16'h1234);
    chk("R6 shown bank untouched", ram0[2], 16'h0000);
    set_vblank(1); write_fs(1); set_vblank(0);
    chk("R6 scan bank after swap", scan_bank, 1);
    cpu_read(4, d, b);
    chk("R6 read bank", b, 0);
    chk("R6 read data", d, 16'h0000);
    cpu_write(4, 16'h5678, 2'b11);
    cpu_read(4, d, b);
    chk("R6 readback", d, 16'h5678);
    set_vblank(1); write_fs(0); set_vblank(0);
    cpu_read(4, d, b);
    chk("R6 other bank", d, 16'h1234);
  endtask

  task automatic t_alias;
    logic [DW-1:0] d;
    logic b;
    cpu_write(16, 16'hAABB, 2'b11);
    cpu_write(16 | ALIAS, 16'h00CC, 2'b11);
    cpu_read(16, d, b);
    chk("R8 high zero kept", d, 16'hAACC);
    cpu_write(16 | ALIAS, 16'h1100, 2'b11);
    cpu_read(16, d, b);
    chk("R8 low zero kept", d, 16'h11CC);
    cpu_write(16 | ALIAS, 16'h0077, 2'b10);
    cpu_read(16, d, b);
    chk("R8 byte zero suppressed", d, 16'h11CC);
    cpu_write(16 | ALIAS, 16'h0000, 2'b01);
    cpu_read(16, d, b);
    chk("R8 low byte zero suppressed", d, 16'h11CC);
    cpu_write(16 | ALIAS, 16'h0055, 2'b01);
    cpu_read(16, d, b);
    chk("R8 byte nonzero written", d, 16'h1155);
    cpu_write(16, 16'h0000, 2'b11);
    cpu_read(16 | ALIAS, d, b);
    chk("R7 plain zero written", d, 16'h0000);
  endtask

  task automatic t_palette;
    set_mode(8'h81);
    chk("R9 pulse on change", pal_dirty, 1);
    @(negedge clk);
    chk("R9 single cycle", pal_dirty, 0);
    set_mode(8'h82);
    chk("R9 no pulse same", pal_dirty, 0);
    set_mode(8'h01);
    chk("R9 pulse on clear", pal_dirty, 1);
  endtask

  task automatic t_blank;
    set_mode(8'h01);
    set_vblank(0); #1;
    chk("R10 visible", blank, 0);
    set_vblank(1); #1;
    chk("R10 vblank", blank, 1);
    set_vblank(0);
    set_mode(8'h00); #1;
    chk("R10 mode off", blank, 1);
    set_mode(8'h01);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_deferred();
    t_immediate();
    t_display_off();
    t_steer();
    t_alias();
    t_palette();
    t_blank();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule